// File: doc/BRIEF.md
# Phase-Dithered Sine Synthesizer

This block generates a digital sine wave by stepping a 32-bit phase register by a programmable increment every clock and turning the upper phase bits into a 14-bit two's-complement sample through a sine table. The table has 8192 entries and is computed when the design is elaborated. A synchronous phase-reset request reloads the phase register with a programmable start phase, so several generators can be brought into a known phase relation.

Using only the upper 13 bits of the phase throws away 19 fractional bits, and the resulting error repeats with the output, which shows up as discrete spurs. When the dither input is high, a pseudo-random word from an internal 18-bit shift register is added to the phase below the truncation point before the table address is taken. Each lookup then lands on the truncated address or on the next one at random, and the error turns into broadband noise. The phase register itself never holds the dither. With dither low the output is the plain truncated lookup.

The sample for a given phase register value appears on the output three clocks later, and that latency is the same in both modes.

Top module: `dither_dds`

## Requirements
- R1: When the registered phase-reset request is low, the phase register adds the registered frequency word at each rising clock edge, modulo 2^32.
- R2: When the registered phase-reset request is high, the phase register loads the registered start phase at the next rising edge instead of accumulating.
- R3: The frequency word, start phase, phase-reset request and dither enable are each captured in one register before use. The sample for a phase register value P held after edge k appears on `sine_out` after edge k+3.
- R4: With the registered dither enable low, the table address is bits 31..19 of the phase register, with no dither added.
- R5: With the registered dither enable high, the table address is bits 31..19 of (phase + dither) modulo 2^32. The dither is the 18-bit shift-register state shifted left by one bit, so it is below 2^19. The output therefore equals the table entry at the truncated address a or at (a+1) mod 8192.
- R6: The dither shift register is 18 bits and resets to all zeros. At each rising edge it moves bits 16..0 up to bits 17..1, and bit 0 takes the XNOR of bits 16 and 17. It never reaches the all-ones state.
- R7: Table entry k is sin(2*pi*k/8192)*8192, rounded to nearest with ties away from zero and saturated to -8192..+8191. The entries at 0, 2048, 4096 and 6144 are 0, +8191, 0 and -8192.
- R8: While the active-low asynchronous reset is low, `sine_out` is 0. On leaving reset the phase-reset request register is high, so the first phase loaded is the reset start phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_sync | input | 1 | Synchronous request to load the start phase |
| freq_word | input | 32 | Phase increment per clock |
| start_phase | input | 32 | Phase loaded on a phase-reset request |
| dither_en | input | 1 | 1 adds dither below the truncation point, 0 uses plain truncation |
| sine_out | output | 14 | Two's-complement sine sample |

## Verification
A quarter-rate frequency word with dither off makes the output cycle through the four cardinal table entries, so the table scale, the saturation and the three-cycle latency are each visible as a fixed value. The same word with dither on, a zero word that freezes the phase, and a start phase just below the wrap point separate the dither from the phase register. In these cases any change in the output can only come from the shift register, and the dithered address must wrap from 8191 to 0. Randomly chosen words, phase-reset pulses, mode changes and a mid-run reset then compare every sample against a bench model of the phase, the shift register and the table. Each dithered sample is also checked to lie on the truncated entry or the next one.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Quantized sine sample for table index k, with aw address bits and sw sample bits.
  function automatic int sine_code(int k, int aw, int sw);
    real full_turn;
    real amp;
    real scaled;
    int  q;
    int  hi;
    int  lo;
    full_turn = 2.0 ** aw;
    amp       = 2.0 ** (sw - 1);
    scaled    = $sin(6.283185307179586 * real'(k) / full_turn) * amp;
    if (scaled >= 0.0) q = $rtoi(scaled + 0.5);
    else               q = -$rtoi(0.5 - scaled);
    hi = (1 << (sw - 1)) - 1;
    lo = -(1 << (sw - 1));
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return q;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic [PHASE_W-1:0] fcw_in,
  input  logic [PHASE_W-1:0] start_in,
  output logic               sync_q,
  output logic [PHASE_W-1:0] fcw_q,
  output logic [PHASE_W-1:0] start_q,
  output logic [PHASE_W-1:0] acc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b1;
      fcw_q   <= '0;
      start_q <= '0;
    end else begin
      sync_q  <= sync_in;
      fcw_q   <= fcw_in;
      start_q <= start_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (sync_q) acc_q <= start_q;
    else             acc_q <= acc_q + fcw_q;
  end

endmodule

// File: rtl/dds_lfsr.sv
module dds_lfsr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic fb;
  assign fb = ~(state[W-2] ^ state[W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= {state[W-2:0], fb};
  end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W   = 13,
  parameter int SAMPLE_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  output logic signed [SAMPLE_W-1:0] data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [SAMPLE_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int CODE = dds_pkg::sine_code(g, ADDR_W, SAMPLE_W);
    assign tbl[g] = SAMPLE_W'(CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else        data <= tbl[addr];
  end

endmodule

// File: rtl/dither_dds.sv
module dither_dds #(
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 13,
  parameter int SAMPLE_W = 14,
  parameter int LFSR_W   = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phase_sync,
  input  logic [31:0]                freq_word,
  input  logic [31:0]                start_phase,
  input  logic                       dither_en,
  output logic signed [13:0]         sine_out
);

  localparam int DROP_W = PHASE_W - ADDR_W;
  localparam int PAD_W  = DROP_W - LFSR_W;

  // Named internal events, observed by the bound checker.
  logic                       sync_q;
  logic [PHASE_W-1:0]         fcw_q;
  logic [PHASE_W-1:0]         start_q;
  logic [PHASE_W-1:0]         acc_q;
  logic                       den_q;
  logic [LFSR_W-1:0]          lfsr_q;
  logic [PHASE_W-1:0]         dither_word;
  logic [ADDR_W-1:0]          addr_q;
  logic signed [SAMPLE_W-1:0] tab_q;

  // Table address: top bits of the phase, optionally pushed by the dither word.
  function automatic logic [ADDR_W-1:0] pick_addr(
    input logic [PHASE_W-1:0] phase,
    input logic [PHASE_W-1:0] dith,
    input logic               en
  );
    logic [PHASE_W-1:0] sum;
    sum = phase + (en ? dith : '0);
    return sum[PHASE_W-1:DROP_W];
  endfunction

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (phase_sync),
    .fcw_in   (freq_word),
    .start_in (start_phase),
    .sync_q   (sync_q),
    .fcw_q    (fcw_q),
    .start_q  (start_q),
    .acc_q    (acc_q)
  );

  dds_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_q)
  );

  assign dither_word = PHASE_W'(lfsr_q) << PAD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      den_q  <= dither_en;
      addr_q <= pick_addr(acc_q, dither_word, den_q);
    end
  end

  dds_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr_q),
    .data  (tab_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sine_out <= '0;
    else        sine_out <= tab_q;
  end

endmodule

// File: rtl/dither_dds_chk.sv
module dither_dds_chk #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 13,
  parameter int LFSR_W  = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_q,
  input logic [PHASE_W-1:0] fcw_q,
  input logic [PHASE_W-1:0] start_q,
  input logic [PHASE_W-1:0] acc_q,
  input logic               den_q,
  input logic [LFSR_W-1:0]  lfsr_q,
  input logic [ADDR_W-1:0]  addr_q
);

  localparam int DROP_W = PHASE_W - ADDR_W;

  // R1: accumulate the registered word
  a_r1_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |=> acc_q == $past(acc_q) + $past(fcw_q));

  // R2: load the start phase on a registered request
  a_r2_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> acc_q == $past(start_q));

  // R4: plain truncation when dither is off
  a_r4_plain_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !den_q |=> addr_q == $past(acc_q[PHASE_W-1:DROP_W]));

  // R5: dithered address is the truncated one or the next
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    den_q |=> ADDR_W'(addr_q - $past(acc_q[PHASE_W-1:DROP_W])) <= ADDR_W'(1));

  // R6: shift with XNOR feedback of the two top stages
  a_r6_lfsr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> lfsr_q == {$past(lfsr_q[LFSR_W-2:0]),
                         ~($past(lfsr_q[LFSR_W-2]) ^ $past(lfsr_q[LFSR_W-1]))});

  // R6: never in the lockup state
  a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '1);

endmodule

bind dither_dds dither_dds_chk #(
  .PHASE_W (PHASE_W),
  .ADDR_W  (ADDR_W),
  .LFSR_W  (LFSR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sync_q  (sync_q),
  .fcw_q   (fcw_q),
  .start_q (start_q),
  .acc_q   (acc_q),
  .den_q   (den_q),
  .lfsr_q  (lfsr_q),
  .addr_q  (addr_q)
);

// File: tb/test_dither_dds.sv
module test_dither_dds;

  localparam time CLK_PERIOD = 10ns;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               phase_sync;
  logic [31:0]        freq_word;
  logic [31:0]        start_phase;
  logic               dither_en;
  logic signed [13:0] sine_out;

  int n_checks = 0;
  int n_errors = 0;
  bit dir_mode = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dither_dds i_dither_dds (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_sync  (phase_sync),
    .freq_word   (freq_word),
    .start_phase (start_phase),
    .dither_en   (dither_en),
    .sine_out    (sine_out)
  );

  // Reference sine, rounding half away from zero, clamped (R7).
  function automatic int ref_sine(int a);
    real v;
    real mag;
    int  q;
    v   = 8192.0 * $sin(real'(a) * (2.0 * 3.141592653589793) / 8192.0);
    mag = (v < 0.0) ? -v : v;
    q   = int'($floor(mag + 0.5));
    if (v < 0.0) q = -q;
    if (q > 8191)  q = 8191;
    if (q < -8192) q = -8192;
    return q;
  endfunction

  function automatic logic [12:0] top13(logic [31:0] p);
    return p[31:19];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench model of the registered inputs, phase and dither source.
  logic        m_sync, m_den;
  logic [31:0] m_fcw, m_start, m_acc;
  logic [17:0] m_lfsr;
  logic [12:0] p1_plain, p2_plain, p3_plain;
  logic [12:0] p1_dith, p2_dith, p3_dith;
  logic        p1_den, p2_den, p3_den;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 1'b1; m_den <= 1'b0;
      m_fcw <= '0; m_start <= '0; m_acc <= '0; m_lfsr <= '0;
      p1_plain <= '0; p2_plain <= '0; p3_plain <= '0;
      p1_dith <= '0; p2_dith <= '0; p3_dith <= '0;
      p1_den <= 1'b0; p2_den <= 1'b0; p3_den <= 1'b0;
    end else begin
      m_sync  <= phase_sync;
      m_den   <= dither_en;
      m_fcw   <= freq_word;
      m_start <= start_phase;
      m_acc   <= m_sync ? m_start : m_acc + m_fcw;
      m_lfsr  <= {m_lfsr[16:0], ~(m_lfsr[16] ^ m_lfsr[17])};
      p1_plain <= top13(m_acc);
      p1_dith  <= top13(m_acc + (m_den ? {13'd0, m_lfsr, 1'b0} : 32'd0));
      p1_den   <= m_den;
      p2_plain <= p1_plain; p2_dith <= p1_dith; p2_den <= p1_den;
      p3_plain <= p2_plain; p3_dith <= p2_dith; p3_den <= p2_den;
    end
  end

  function automatic int cardinal(logic [1:0] q);
    case (q)
      2'd0:    return 0;
      2'd1:    return 8191;
      2'd2:    return 0;
      default: return -8192;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        check(sine_out == 0, "R8 output zero in reset", sine_out, 0);
      end else if (p3_den) begin
        check(sine_out == ref_sine(p3_dith), "R5 R6 dithered sample",
              sine_out, ref_sine(p3_dith));
        check(sine_out == ref_sine(p3_plain) ||
              sine_out == ref_sine(int'(p3_plain + 13'd1)),
              "R5 within one table step", sine_out, ref_sine(p3_plain));
      end else begin
        check(sine_out == ref_sine(p3_plain), "R1 R2 R3 R4 plain sample",
              sine_out, ref_sine(p3_plain));
        if (dir_mode)
          check(sine_out == cardinal(p3_plain[12:11]), "R7 cardinal entries",
                sine_out, cardinal(p3_plain[12:11]));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_pulse(logic [31:0] sp);
    start_phase = sp;
    phase_sync  = 1'b1;
    step(1);
    phase_sync  = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; phase_sync = 1'b0; freq_word = '0;
    start_phase = '0; dither_en = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(4);

    // Directed: quarter-rate word, plain truncation (R7, R3)
    freq_word = 32'h4000_0000;
    sync_pulse(32'h0);
    step(6);
    dir_mode = 1'b1;
    step(32);
    dir_mode = 1'b0;

    // Same word with dither on (R5, R6)
    dither_en = 1'b1;
    step(64);

    // Frozen phase: only the dither can move the output (R5)
    freq_word = 32'h0;
    sync_pulse(32'h1234_5678);
    step(40);

    // Phase just below the wrap point, dithered address wraps to 0
    freq_word = 32'h0000_0100;
    sync_pulse(32'hFFFF_F000);
    step(64);

    // Largest word, wraps every cycle (R1)
    freq_word = 32'hFFFF_FFFF;
    dither_en = 1'b0;
    step(32);

    // Mid-run asynchronous reset (R8)
    @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // Constrained random blocks
    for (int blk = 0; blk < 60; blk++) begin
      freq_word = $urandom;
      dither_en = 1'($urandom % 2);
      if ($urandom % 4 == 0) sync_pulse($urandom);
      step(64);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule